// File: doc/BRIEF.md
# Invalid Opcode Fault Detector

This block sits beside the decode and retire stages of a core. For every decoded instruction it receives a set of class flags from the decoder, together with the processor feature words, the control bits and the operating-mode bits in force at that moment. It decides whether the instruction must raise the invalid-opcode fault (vector 6). That decision is a one-bit tag. The tag is stored with the instruction pointer in a small in-order retirement queue.

Nothing is signalled when the instruction is decoded or executed speculatively. The fault appears only when the tagged instruction reaches the head of the queue and is retired. It is a one-cycle pulse carrying vector 6 and the pointer of the faulting instruction itself. Every younger entry is then discarded. A flush input empties the queue, so instructions on a mispredicted path never fault.

Top module: `ud_fault_detect`

## Requirements
- R1: An instruction flagged as a reserved opcode, as having an operand type invalid for its opcode, or as the deliberate-undefined opcode is always tagged.
- R2: A packed-integer SIMD instruction is tagged when bit 23 of the standard feature word is 0. A streaming SIMD instruction is tagged when the feature bit for its generation is 0. Generation code 0 selects standard bit 25, code 1 selects standard bit 26, and codes 2 and 3 select extended bit 0.
- R3: With the emulation control bit at 1, packed-integer and streaming SIMD instructions are tagged unless they carry the emulation-exempt flag.
- R4: With the extended-state-save enable bit at 0, streaming SIMD instructions are tagged unless they carry the save-exempt flag.
- R5: A streaming SIMD instruction flagged as raising a SIMD floating-point exception is tagged when the SIMD-exception enable bit is 0.
- R6: A lock-prefixed instruction is tagged when it is not lockable, or when it is lockable but its destination is not memory.
- R7: A segment/descriptor system instruction is tagged in real-address mode or virtual-8086 mode. A system-management return is tagged whenever the core is not in system-management mode.
- R8: Enqueueing a tagged instruction raises nothing. Retiring the head entry raises `fault_valid` on the next cycle only when that entry is tagged. The pulse lasts one cycle, with `fault_vector` equal to 6 and `fault_ip` equal to that entry's pointer. `fault_vector` reads 0 when no fault is signalled.
- R9: Retiring a tagged entry discards all younger entries, and `q_empty` is 1 in the following cycle.
- R10: `flush` empties the queue in one cycle and raises no fault. When `flush` and `retire` coincide, the flush wins.
- R11: The queue holds DEPTH entries. `enq_ready` is 0 when the queue is full, and an enqueue attempted while full is dropped.
- R12: Feature, control and mode inputs are sampled at enqueue. Later changes do not alter an instruction's tag.
- R13: After reset, `q_empty` and `enq_ready` are 1, and `fault_valid` and `fault_vector` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all queued entries |
| enq_valid | input | 1 | Enqueue the decoded instruction on the class inputs |
| op_reserved | input | 1 | Reserved or invalid opcode |
| op_bad_operand | input | 1 | Operand type invalid for the opcode |
| op_undef | input | 1 | Deliberate-undefined opcode |
| op_pint | input | 1 | Packed-integer SIMD instruction |
| op_simd | input | 1 | Streaming SIMD instruction |
| op_simd_gen | input | 2 | Streaming SIMD generation code |
| op_em_exempt | input | 1 | Exempt from the emulation check |
| op_fx_exempt | input | 1 | Exempt from the save-enable check |
| op_simd_fpx | input | 1 | Would raise a SIMD floating-point exception |
| op_lock | input | 1 | Lock prefix present |
| op_lockable | input | 1 | Instruction may be locked |
| op_dst_mem | input | 1 | Destination is memory |
| op_sysdesc | input | 1 | Segment/descriptor system instruction |
| op_smret | input | 1 | System-management return |
| feat_std | input | FEAT_W | Standard feature word |
| feat_ext | input | FEAT_W | Extended feature word |
| ctl_em | input | 1 | Emulation control bit |
| ctl_fxsave_en | input | 1 | Extended-state-save enable |
| ctl_simdx_en | input | 1 | SIMD-exception enable |
| mode_real | input | 1 | Real-address mode |
| mode_v86 | input | 1 | Virtual-8086 mode |
| mode_smm | input | 1 | System-management mode |
| enq_ip | input | IP_W | Instruction pointer of the enqueued instruction |
| retire | input | 1 | Retire the head entry |
| enq_ready | output | 1 | Queue can accept an entry |
| q_empty | output | 1 | Queue holds no entry |
| fault_valid | output | 1 | Invalid-opcode fault pulse |
| fault_vector | output | 8 | Fault vector (6 while valid) |
| fault_ip | output | IP_W | Saved instruction pointer |

## Verification
The bench builds the block with DEPTH set to 4. At that depth the full, wrap-around and overflow-drop cases come up after a handful of enqueues, and every pointer value is used many times over. Each tag condition is swept over all combinations of the flags and control bits that feed it. Several hundred pseudo-random four-entry batches are then retired in order, with the first tagged position predicted arithmetically. This exercises the younger-entry discard at every queue position and across pointer wrap.

// File: rtl/ud_pkg.sv
package ud_pkg;

   localparam logic [7:0] UD_VECTOR = 8'd6;

   typedef struct packed {
      logic       reserved;
      logic       bad_operand;
      logic       undef;
      logic       pint;
      logic       simd;
      logic [1:0] simd_gen;
      logic       em_exempt;
      logic       fx_exempt;
      logic       simd_fpx;
      logic       lock;
      logic       lockable;
      logic       dst_mem;
      logic       sysdesc;
      logic       smret;
   } ud_class_t;

   typedef struct packed {
      logic em;
      logic fxsave_en;
      logic simdx_en;
   } ud_ctl_t;

   typedef struct packed {
      logic real_mode;
      logic v86;
      logic smm;
   } ud_mode_t;

endpackage

// File: rtl/ud_tag_logic.sv
module ud_tag_logic
   import ud_pkg::*;
#(
   parameter int FEAT_W   = 32,
   parameter int PINT_BIT = 23,
   parameter int GEN1_BIT = 25,
   parameter int GEN2_BIT = 26,
   parameter int GEN3_BIT = 0
) (
   input  ud_class_t          cls,
   input  logic [FEAT_W-1:0]  feat_std,
   input  logic [FEAT_W-1:0]  feat_ext,
   input  ud_ctl_t            ctl,
   input  ud_mode_t           mode,
   output logic               tag
);

   generate
      if (PINT_BIT >= FEAT_W || GEN1_BIT >= FEAT_W ||
          GEN2_BIT >= FEAT_W || GEN3_BIT >= FEAT_W) begin : g_bad_bit
         $error("ud_tag_logic: feature bit index outside feature word");
      end
   endgenerate

   logic gen_present;
   logic c_always, c_feature, c_em, c_fx, c_fpx, c_lock, c_mode;

   always_comb begin
      unique case (cls.simd_gen)
         2'd0:    gen_present = feat_std[GEN1_BIT];
         2'd1:    gen_present = feat_std[GEN2_BIT];
         default: gen_present = feat_ext[GEN3_BIT];
      endcase
   end

   always_comb begin
      c_always  = cls.reserved | cls.bad_operand | cls.undef;
      c_feature = (cls.pint & ~feat_std[PINT_BIT]) | (cls.simd & ~gen_present);
      c_em      = (cls.pint | cls.simd) & ctl.em & ~cls.em_exempt;
      c_fx      = cls.simd & ~ctl.fxsave_en & ~cls.fx_exempt;
      c_fpx     = cls.simd & cls.simd_fpx & ~ctl.simdx_en;
      c_lock    = cls.lock & (~cls.lockable | ~cls.dst_mem);
      c_mode    = (cls.sysdesc & (mode.real_mode | mode.v86)) |
                  (cls.smret & ~mode.smm);
      tag       = c_always | c_feature | c_em | c_fx | c_fpx | c_lock | c_mode;
   end

   logic unused_feat;
   assign unused_feat = ^{feat_std, feat_ext};

endmodule

// File: rtl/ud_retire_queue.sv
module ud_retire_queue #(
   parameter int DEPTH = 8,
   parameter int IP_W  = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            push,
   input  logic            push_tag,
   input  logic [IP_W-1:0] push_ip,
   input  logic            pop,
   output logic            head_tag,
   output logic [IP_W-1:0] head_ip,
   output logic            empty,
   output logic            full
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ud_retire_queue: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [PTR_W-1:0] head_q, tail_q;
   logic [DEPTH-1:0] valid_q;
   logic [DEPTH-1:0] tag_q;
   logic [IP_W-1:0]  ip_q [DEPTH];

   logic do_push, do_pop;
   assign do_push = push & ~clear & ~full;
   assign do_pop  = pop  & ~clear & ~empty;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid_q[i] <= 1'b0;
               tag_q[i]   <= 1'b0;
               ip_q[i]    <= '0;
            end else if (clear) begin
               valid_q[i] <= 1'b0;
            end else if (do_push && tail_q == PTR_W'(i)) begin
               valid_q[i] <= 1'b1;
               tag_q[i]   <= push_tag;
               ip_q[i]    <= push_ip;
            end else if (do_pop && head_q == PTR_W'(i)) begin
               valid_q[i] <= 1'b0;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else if (clear) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         if (do_push) tail_q <= tail_q + 1'b1;
         if (do_pop)  head_q <= head_q + 1'b1;
      end
   end

   assign empty    = ~valid_q[head_q];
   assign full     = valid_q[tail_q];
   assign head_tag = tag_q[head_q];
   assign head_ip  = ip_q[head_q];

endmodule

// File: rtl/ud_fault_detect.sv
module ud_fault_detect
   import ud_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int IP_W   = 32,
   parameter int FEAT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              enq_valid,
   input  logic              op_reserved,
   input  logic              op_bad_operand,
   input  logic              op_undef,
   input  logic              op_pint,
   input  logic              op_simd,
   input  logic [1:0]        op_simd_gen,
   input  logic              op_em_exempt,
   input  logic              op_fx_exempt,
   input  logic              op_simd_fpx,
   input  logic              op_lock,
   input  logic              op_lockable,
   input  logic              op_dst_mem,
   input  logic              op_sysdesc,
   input  logic              op_smret,
   input  logic [FEAT_W-1:0] feat_std,
   input  logic [FEAT_W-1:0] feat_ext,
   input  logic              ctl_em,
   input  logic              ctl_fxsave_en,
   input  logic              ctl_simdx_en,
   input  logic              mode_real,
   input  logic              mode_v86,
   input  logic              mode_smm,
   input  logic [IP_W-1:0]   enq_ip,
   input  logic              retire,
   output logic              enq_ready,
   output logic              q_empty,
   output logic              fault_valid,
   output logic [7:0]        fault_vector,
   output logic [IP_W-1:0]   fault_ip
);

   ud_class_t cls;
   ud_ctl_t   ctl;
   ud_mode_t  mode;
   logic      new_tag;

   assign cls = '{reserved: op_reserved, bad_operand: op_bad_operand,
                  undef: op_undef, pint: op_pint, simd: op_simd,
                  simd_gen: op_simd_gen, em_exempt: op_em_exempt,
                  fx_exempt: op_fx_exempt, simd_fpx: op_simd_fpx,
                  lock: op_lock, lockable: op_lockable, dst_mem: op_dst_mem,
                  sysdesc: op_sysdesc, smret: op_smret};
   assign ctl  = '{em: ctl_em, fxsave_en: ctl_fxsave_en, simdx_en: ctl_simdx_en};
   assign mode = '{real_mode: mode_real, v86: mode_v86, smm: mode_smm};

   ud_tag_logic #(.FEAT_W(FEAT_W)) u_tag (
      .cls      (cls),
      .feat_std (feat_std),
      .feat_ext (feat_ext),
      .ctl      (ctl),
      .mode     (mode),
      .tag      (new_tag)
   );

   logic            head_tag, empty, full;
   logic [IP_W-1:0] head_ip;
   logic            do_retire, kill, clear;

   assign do_retire = retire & ~flush & ~empty;
   assign kill      = do_retire & head_tag;
   assign clear     = flush | kill;

   ud_retire_queue #(.DEPTH(DEPTH), .IP_W(IP_W)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .push     (enq_valid),
      .push_tag (new_tag),
      .push_ip  (enq_ip),
      .pop      (do_retire),
      .head_tag (head_tag),
      .head_ip  (head_ip),
      .empty    (empty),
      .full     (full)
   );

   logic            fv_q;
   logic [IP_W-1:0] fip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fv_q  <= 1'b0;
         fip_q <= '0;
      end else begin
         fv_q <= kill;
         if (kill) fip_q <= head_ip;
      end
   end

   assign enq_ready    = ~full;
   assign q_empty      = empty;
   assign fault_valid  = fv_q;
   assign fault_vector = fv_q ? UD_VECTOR : 8'd0;
   assign fault_ip     = fip_q;

endmodule

// File: rtl/ud_fault_detect_chk.sv
module ud_fault_detect_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       flush,
   input logic       retire,
   input logic       enq_valid,
   input logic       enq_ready,
   input logic       q_empty,
   input logic       fault_valid,
   input logic [7:0] fault_vector
);

   p_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> fault_vector == 8'd6);

   p_idle_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_valid |-> fault_vector == 8'd0);

   p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |=> !fault_valid);

   p_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_valid) |-> $past(retire) && !$past(flush) && !$past(q_empty));

   p_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> q_empty);

   p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> q_empty && !fault_valid);

   p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      q_empty |-> enq_ready);

   p_full_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!enq_ready && !retire && !flush) |=> !enq_ready);

   p_enq_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && enq_ready && !flush && !(retire && !q_empty)) |=> !q_empty);

endmodule

bind ud_fault_detect ud_fault_detect_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .flush        (flush),
   .retire       (retire),
   .enq_valid    (enq_valid),
   .enq_ready    (enq_ready),
   .q_empty      (q_empty),
   .fault_valid  (fault_valid),
   .fault_vector (fault_vector)
);

// File: tb/ud_fault_detect_test.sv
module ud_fault_detect_test;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 4;
   localparam int IP_W   = 32;
   localparam int FEAT_W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 0, enq_valid = 0, retire = 0;
   logic op_reserved = 0, op_bad_operand = 0, op_undef = 0, op_pint = 0, op_simd = 0;
   logic [1:0] op_simd_gen = 0;
   logic op_em_exempt = 0, op_fx_exempt = 0, op_simd_fpx = 0, op_lock = 0;
   logic op_lockable = 0, op_dst_mem = 0, op_sysdesc = 0, op_smret = 0;
   logic [FEAT_W-1:0] feat_std = '1, feat_ext = '1;
   logic ctl_em = 0, ctl_fxsave_en = 1, ctl_simdx_en = 1;
   logic mode_real = 0, mode_v86 = 0, mode_smm = 0;
   logic [IP_W-1:0] enq_ip = '0;
   logic enq_ready, q_empty, fault_valid;
   logic [7:0] fault_vector;
   logic [IP_W-1:0] fault_ip;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [31:0] lfsr = 32'hACE1_2468;
   logic [IP_W-1:0] ip_ctr = 32'h1000;

   always #(CLK_PERIOD/2) clk = ~clk;

   ud_fault_detect #(.DEPTH(DEPTH), .IP_W(IP_W), .FEAT_W(FEAT_W)) uut (.*);

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic model_tag();
      logic gp;
      case (op_simd_gen)
         2'd0: gp = feat_std[25];
         2'd1: gp = feat_std[26];
         default: gp = feat_ext[0];
      endcase
      return op_reserved | op_bad_operand | op_undef
           | (op_pint & !feat_std[23]) | (op_simd & !gp)
           | ((op_pint | op_simd) & ctl_em & !op_em_exempt)
           | (op_simd & !ctl_fxsave_en & !op_fx_exempt)
           | (op_simd & op_simd_fpx & !ctl_simdx_en)
           | (op_lock & (!op_lockable | !op_dst_mem))
           | (op_sysdesc & (mode_real | mode_v86))
           | (op_smret & !mode_smm);
   endfunction

   task automatic clean();
      {op_reserved, op_bad_operand, op_undef, op_pint, op_simd} = '0;
      op_simd_gen = 0;
      {op_em_exempt, op_fx_exempt, op_simd_fpx, op_lock, op_lockable} = '0;
      {op_dst_mem, op_sysdesc, op_smret} = '0;
      feat_std = '1; feat_ext = '1;
      ctl_em = 0; ctl_fxsave_en = 1; ctl_simdx_en = 1;
      mode_real = 0; mode_v86 = 0; mode_smm = 0;
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
   endtask

   // enqueue with inputs already set; called right after a negedge
   task automatic enq_one();
      ip_ctr = ip_ctr + 4;
      enq_ip = ip_ctr;
      enq_valid = 1;
      @(negedge clk);
      enq_valid = 0;
   endtask

   task automatic retire_one(input bit exp, input logic [IP_W-1:0] exp_ip, input string req);
      retire = 1;
      @(negedge clk);
      retire = 0;
      check(fault_valid == exp, req, fault_valid, exp);
      if (exp) begin
         check(fault_vector == 8'd6, req, fault_vector, 6);
         check(fault_ip == exp_ip, req, fault_ip, exp_ip);
      end
   endtask

   // single instruction: enqueue, confirm no fault at enqueue, retire, check
   task automatic run_one(input bit exp, input string req);
      logic [IP_W-1:0] ip;
      @(negedge clk);
      enq_one();
      ip = enq_ip;
      check(fault_valid == 0, "R8 no fault at enqueue", fault_valid, 0);
      retire_one(exp, ip, req);
      @(negedge clk);
      check(fault_valid == 0 && q_empty == 1, req, {fault_valid, q_empty}, 1);
      clean();
   endtask

   initial begin
      repeat (CLK_PERIOD * 20000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R13 reset state
      check(q_empty == 1 && enq_ready == 1, "R13 queue idle", {q_empty, enq_ready}, 3);
      check(fault_valid == 0 && fault_vector == 0, "R13 fault idle", {fault_valid, fault_vector}, 0);

      // R1
      run_one(0, "R1 clean");
      op_reserved = 1;    run_one(1, "R1 reserved");
      op_bad_operand = 1; run_one(1, "R1 bad operand");
      op_undef = 1;       run_one(1, "R1 undefined");

      // R2
      for (int b = 0; b < 2; b++) begin
         op_pint = 1; feat_std[23] = b[0]; run_one(!b[0], "R2 packed-int feature");
         for (int g = 0; g < 4; g++) begin
            op_simd = 1; op_simd_gen = g[1:0];
            if (g == 0) feat_std[25] = b[0];
            else if (g == 1) feat_std[26] = b[0];
            else feat_ext[0] = b[0];
            run_one(!b[0], "R2 simd generation feature");
         end
      end

      // R3
      for (int v = 0; v < 8; v++) begin
         op_pint = v[0]; op_simd = !v[0]; ctl_em = v[1]; op_em_exempt = v[2];
         run_one(v[1] & !v[2], "R3 emulation check");
      end

      // R4
      for (int v = 0; v < 8; v++) begin
         op_simd = v[0]; ctl_fxsave_en = v[1]; op_fx_exempt = v[2];
         run_one(v[0] & !v[1] & !v[2], "R4 save-enable check");
      end

      // R5
      for (int v = 0; v < 8; v++) begin
         op_simd = v[0]; op_simd_fpx = v[1]; ctl_simdx_en = v[2];
         op_fx_exempt = 1;
         run_one(v[0] & v[1] & !v[2], "R5 simd exception enable");
      end

      // R6
      for (int v = 0; v < 8; v++) begin
         op_lock = v[0]; op_lockable = v[1]; op_dst_mem = v[2];
         run_one(v[0] & (!v[1] | !v[2]), "R6 lock prefix");
      end

      // R7
      for (int v = 0; v < 8; v++) begin
         op_sysdesc = v[0]; mode_real = v[1]; mode_v86 = v[2];
         run_one(v[0] & (v[1] | v[2]), "R7 descriptor instr mode");
      end
      for (int v = 0; v < 4; v++) begin
         op_smret = v[0]; mode_smm = v[1];
         run_one(v[0] & !v[1], "R7 system-management return");
      end

      // R12: state sampled at enqueue
      begin
         logic [IP_W-1:0] ip;
         @(negedge clk);
         op_simd = 1; ctl_fxsave_en = 0; enq_one(); ip = enq_ip;
         ctl_fxsave_en = 1;
         retire_one(1, ip, "R12 tag kept after control change");
         clean();
         @(negedge clk);
         op_simd = 1; ctl_fxsave_en = 1; enq_one(); ip = enq_ip;
         ctl_fxsave_en = 0;
         retire_one(0, ip, "R12 clean kept after control change");
         clean();
      end

      // R11: capacity and dropped enqueue when full
      @(negedge clk);
      for (int i = 0; i < DEPTH; i++) enq_one();
      check(enq_ready == 0, "R11 full after DEPTH", enq_ready, 0);
      op_undef = 1; enq_one(); clean();
      for (int i = 0; i < DEPTH; i++) retire_one(0, '0, "R11 dropped enqueue");
      check(q_empty == 1, "R11 empty after DEPTH retires", q_empty, 1);
      retire_one(0, '0, "R11 nothing beyond DEPTH");

      // R9: younger entries discarded
      begin
         logic [IP_W-1:0] ipx;
         @(negedge clk);
         enq_one();
         op_reserved = 1; enq_one(); ipx = enq_ip;
         enq_one(); clean(); enq_one();
         retire_one(0, '0, "R9 clean head");
         retire_one(1, ipx, "R9 tagged second");
         check(q_empty == 1, "R9 younger discarded", q_empty, 1);
         retire_one(0, '0, "R9 no later fault");
      end

      // R10: flush
      @(negedge clk);
      op_undef = 1; enq_one(); enq_one(); clean();
      flush = 1; @(negedge clk); flush = 0;
      check(q_empty == 1 && fault_valid == 0, "R10 flush empties", {q_empty, fault_valid}, 2);
      retire_one(0, '0, "R10 no fault after flush");
      op_undef = 1; enq_one(); clean();
      flush = 1; retire = 1; @(negedge clk); flush = 0; retire = 0;
      check(fault_valid == 0 && q_empty == 1, "R10 flush beats retire", {fault_valid, q_empty}, 1);

      // R8: pseudo-random batches retired in order
      for (int bt = 0; bt < 300; bt++) begin
         bit exp_t [DEPTH];
         logic [IP_W-1:0] ips [DEPTH];
         int first;
         first = -1;
         @(negedge clk);
         for (int i = 0; i < DEPTH; i++) begin
            step_lfsr();
            op_reserved = lfsr[0] & lfsr[1] & lfsr[2] & lfsr[3];
            op_pint = lfsr[4] & lfsr[5];
            op_simd = lfsr[6] & lfsr[7];
            op_simd_gen = lfsr[9:8];
            op_em_exempt = lfsr[10]; op_fx_exempt = lfsr[11]; op_simd_fpx = lfsr[12];
            op_lock = lfsr[13] & lfsr[14]; op_lockable = lfsr[15]; op_dst_mem = lfsr[16];
            op_sysdesc = lfsr[17] & lfsr[18]; op_smret = lfsr[19] & lfsr[20] & lfsr[21];
            feat_std[23] = lfsr[22] | lfsr[23]; feat_std[25] = lfsr[24] | lfsr[25];
            feat_std[26] = lfsr[26] | lfsr[27]; feat_ext[0] = lfsr[28] | lfsr[29];
            ctl_em = lfsr[30] & lfsr[31] & lfsr[0];
            ctl_fxsave_en = lfsr[1] | lfsr[5]; ctl_simdx_en = lfsr[3] | lfsr[7];
            mode_real = lfsr[9] & lfsr[11]; mode_v86 = lfsr[13] & lfsr[15];
            mode_smm = lfsr[17];
            exp_t[i] = model_tag();
            if (first < 0 && exp_t[i]) first = i;
            enq_one();
            ips[i] = enq_ip;
         end
         clean();
         for (int i = 0; i < DEPTH; i++) begin
            retire_one(i == first, ips[i], "R8 batch retire order");
            if (i == first) break;
         end
         check(q_empty == 1, "R9 batch ends empty", q_empty, 1);
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule